// File: doc/BRIEF.md
# Two-Wire Debug Link Transaction Master

This block is the master end of a two-wire serial debug link. It drives a link clock, a data line with a separate output enable, and a target-enable line. A host starts one read or write transaction with a single-cycle pulse. The engine then runs the whole exchange on its own:

- it shifts out a 16-bit request header;
- it releases the data line and reads a three-bit acknowledge;
- it resends the header while the target answers WAIT;
- it moves a 32-bit data word and its parity bit in the direction the host asked for.

At the end it reports a two-bit status and, for reads, the captured word and parity bit. It marks the end with a one-cycle done pulse.

The host supplies the write-phase parity bit precomputed inside the request word. The engine computes no parity and does not check the parity it reads back. The link clock half-period is a host-chosen count of system clocks. It is captured at start, so the link rate can be changed between transactions without disturbing a transaction already running.

Top module: `dbg_wire_master`

## Requirements
- R1: During reset and whenever idle, the link clock, data output and output enable are all 1, busy is 0 and done is 0. After reset, status is 0 and the read data and read parity are 0. Target enable is 0 during reset and 1 from the first cycle after reset is released.
- R2: A start pulse while idle drives request bits 15:0 onto the data line, least-significant bit first, one bit per link clock period, with the output enable at 1.
- R3: Each link bit period holds the clock low for DIV+1 system clocks and then high for DIV+1 system clocks. DIV is the divider input captured at start; later changes to the divider input do not affect the running transaction. The data output and output enable change only in the cycle the clock falls, or when the transaction ends.
- R4: After the header, the output enable goes to 0 for four link clocks: one turnaround bit and then three acknowledge bits, least-significant bit first. Each incoming bit is sampled one system clock after the clock falls. The acknowledge is formed from the last three sampled bits.
- R5: Acknowledge code 1 (OK) lets the data phase run; a transaction that completes its data phase reports status 0.
- R6: Acknowledge code 2 (WAIT) makes the engine drive the line again and resend the full header. At most MAX_TRIES headers are sent (8192 by default). If every attempt gets WAIT, the transaction ends with status 2 and no data phase.
- R7: Any acknowledge code other than 1 or 2 ends the transaction with status 3 and no data phase. Status code 1 is never reported.
- R8: On a read with OK, the engine samples 32 data bits least-significant bit first and then one parity bit, with the output enable at 0. It then gives one further undriven clock, and finally drives the data line high with the clock left high.
- R9: On a write with OK, the engine gives one driven turnaround clock with data 0. It then drives the 32 write-data bits least-significant bit first, followed by request bit 16 as the parity bit.
- R10: Every transaction end gives done for exactly one cycle. Status is updated only at a transaction end. The read data and read parity are updated only at the end of a successful read, and are held until then.
- R11: A start pulse while a transaction is running is ignored. The running transaction completes with its original request, and no extra transaction follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Single-cycle request to begin a transaction |
| is_write | input | 1 | 1 selects a write transaction, 0 a read |
| req_word | input | 17 | Bits 15:0 header, bit 16 write-phase parity |
| wr_data | input | DATA_W (32) | Word to send on a write |
| half_div | input | DIV_W (8) | Link clock half-period minus one, in system clocks |
| busy | output | 1 | A transaction is in progress |
| done | output | 1 | One-cycle pulse at every transaction end |
| status | output | 2 | 0 success, 2 WAIT retries exhausted, 3 failed acknowledge |
| rd_data | output | DATA_W (32) | Word captured by the last successful read |
| rd_parity | output | 1 | Parity bit captured by the last successful read |
| line_clk | output | 1 | Link clock, idles high |
| line_do | output | 1 | Data line value driven by the master |
| line_oe | output | 1 | 1 while the master drives the data line |
| line_di | input | 1 | Data line value seen at the pin |
| tgt_en | output | 1 | Target enable, high while the master drives the link clock |

## Verification
The retry decision and the end of the transaction fall on the same bit boundary when the last permitted attempt gets WAIT. In that one cycle, the last acknowledge bit has been judged, the attempt count reads its final value, and the engine must choose between sending another header and reporting a timeout. The bench builds the attempt limit down to a small value and provokes both sides of this edge. One transaction scripts WAIT on every permitted attempt. Another scripts WAIT on all but the last attempt and OK on the last. The outcome is judged from the count of captured header copies, the number of undriven clocks and the status code. A second overlap is a start pulse that arrives while a transfer is on the wire. The bench judges it by checking that the captured bit stream still matches the first request and that exactly one done pulse appears.

// File: rtl/dbg_wire_pkg.sv
package dbg_wire_pkg;

    localparam int HDR_W    = 16;
    localparam int REQ_W    = HDR_W + 1;
    localparam int RSP_BITS = 4;

    localparam logic [2:0] ACK_CODE_OK   = 3'd1;
    localparam logic [2:0] ACK_CODE_WAIT = 3'd2;

    typedef enum logic [1:0] {
        XS_OK      = 2'd0,
        XS_TIMEOUT = 2'd2,
        XS_FAIL    = 2'd3
    } xfer_status_e;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_HDR,
        PH_ACK,
        PH_RD_DATA,
        PH_RD_PAR,
        PH_RD_TURN,
        PH_WR_TURN,
        PH_WR_DATA,
        PH_WR_PAR
    } phase_e;

    typedef enum logic [1:0] {
        VD_PROCEED,
        VD_RESEND,
        VD_TIMEOUT,
        VD_FAIL
    } verdict_e;

    typedef struct packed {
        logic             is_write;
        logic             wr_parity;
        logic [HDR_W-1:0] header;
    } req_t;

    function automatic req_t split_request(input logic [REQ_W-1:0] word, input logic wr);
        req_t r;
        r.is_write  = wr;
        r.wr_parity = word[HDR_W];
        r.header    = word[HDR_W-1:0];
        return r;
    endfunction

    // Turnaround bit sits in bit 0 of the receive shifter; acknowledge above it.
    function automatic logic [2:0] ack_field(input logic [RSP_BITS-1:0] sh);
        return sh[RSP_BITS-1:1];
    endfunction

    function automatic verdict_e judge_ack(input logic [2:0] code, input logic final_try);
        if (code == ACK_CODE_OK)
            return VD_PROCEED;
        else if (code == ACK_CODE_WAIT)
            return final_try ? VD_TIMEOUT : VD_RESEND;
        else
            return VD_FAIL;
    endfunction

endpackage

// File: rtl/dbg_bit_timer.sv
module dbg_bit_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             launch,
    input  logic [DIV_W-1:0] half_cnt,
    output logic             boundary,
    output logic             smp,
    output logic             link_clk
);
    logic             lo_q;
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] hq_q;

    // End of a high half (or idle): a new bit may start here.
    assign boundary = !lo_q && (cnt_q == '0);
    // First system cycle of the low half.
    assign smp      = lo_q && (cnt_q == hq_q);
    assign link_clk = !lo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q  <= 1'b0;
            cnt_q <= '0;
            hq_q  <= '0;
        end else if (boundary) begin
            if (launch) begin
                lo_q  <= 1'b1;
                cnt_q <= half_cnt;
                hq_q  <= half_cnt;
            end
        end else if (cnt_q == '0) begin
            lo_q  <= 1'b0;
            cnt_q <= hq_q;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/dbg_shift_reg.sv
module dbg_shift_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    input  logic         shift_in,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (load)
            q <= load_val;
        else if (shift)
            q <= {shift_in, q[W-1:1]};
    end
endmodule

// File: rtl/dbg_try_ctr.sv
module dbg_try_ctr #(
    parameter int LIMIT = 8192
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic dec,
    output logic final_try
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= CW'(LIMIT);
        else if (dec && (cnt_q != '0))
            cnt_q <= cnt_q - 1'b1;
    end

    assign final_try = (cnt_q == CW'(1));
endmodule

// File: rtl/dbg_wire_master.sv
module dbg_wire_master
    import dbg_wire_pkg::*;
#(
    parameter int DIV_W     = 8,
    parameter int DATA_W    = 32,
    parameter int MAX_TRIES = 8192
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              is_write,
    input  logic [REQ_W-1:0]  req_word,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DIV_W-1:0]  half_div,
    output logic              busy,
    output logic              done,
    output logic [1:0]        status,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_parity,
    output logic              line_clk,
    output logic              line_do,
    output logic              line_oe,
    input  logic              line_di,
    output logic              tgt_en
);
    localparam int SPAN   = (DATA_W > HDR_W) ? DATA_W : HDR_W;
    localparam int LEFT_W = $clog2(SPAN);

    phase_e            phase_q, nxt_phase;
    logic [LEFT_W-1:0] left_q, nxt_left;
    req_t              req_q;
    logic [DIV_W-1:0]  div_q;
    logic              do_q, oe_q, done_q, rpar_q, par_smp_q, tgt_en_q;
    xfer_status_e      status_q, fin_status;
    logic [DATA_W-1:0] rdat_q;

    logic              boundary, smp, link_clk;
    logic              launch, take_req;
    logic              hdr_ld, hdr_sh, wd_sh;
    logic [HDR_W-1:0]  hdr_src;
    logic              do_we, do_nv, oe_we, oe_nv;
    logic              try_ld, try_dec, final_try;
    logic              fin, fin_rd;

    logic [HDR_W-1:0]    hdr_q;
    logic [DATA_W-1:0]   wd_q;
    logic [DATA_W-1:0]   rd_sh_q;
    logic [RSP_BITS-1:0] ack_sh_q;

    dbg_bit_timer #(.DIV_W(DIV_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .launch   (launch),
        .half_cnt ((phase_q == PH_IDLE) ? half_div : div_q),
        .boundary (boundary),
        .smp      (smp),
        .link_clk (link_clk)
    );

    dbg_shift_reg #(.W(HDR_W)) u_hdr_sh (
        .clk      (clk),
        .rst      (rst),
        .load     (hdr_ld),
        .load_val ({1'b0, hdr_src[HDR_W-1:1]}),
        .shift    (hdr_sh),
        .shift_in (1'b0),
        .q        (hdr_q)
    );

    dbg_shift_reg #(.W(DATA_W)) u_wd_sh (
        .clk      (clk),
        .rst      (rst),
        .load     (take_req),
        .load_val (wr_data),
        .shift    (wd_sh),
        .shift_in (1'b0),
        .q        (wd_q)
    );

    dbg_shift_reg #(.W(DATA_W)) u_rd_sh (
        .clk      (clk),
        .rst      (rst),
        .load     (1'b0),
        .load_val ('0),
        .shift    (smp && (phase_q == PH_RD_DATA)),
        .shift_in (line_di),
        .q        (rd_sh_q)
    );

    dbg_shift_reg #(.W(RSP_BITS)) u_ack_sh (
        .clk      (clk),
        .rst      (rst),
        .load     (1'b0),
        .load_val ('0),
        .shift    (smp && (phase_q == PH_ACK)),
        .shift_in (line_di),
        .q        (ack_sh_q)
    );

    dbg_try_ctr #(.LIMIT(MAX_TRIES)) u_tries (
        .clk       (clk),
        .rst       (rst),
        .load      (try_ld),
        .dec       (try_dec),
        .final_try (final_try)
    );

    // Sequencer: every action happens on a bit boundary, where the previous
    // bit ends and (unless the transaction finishes) the next bit starts.
    always_comb begin
        nxt_phase  = phase_q;
        nxt_left   = left_q;
        launch     = 1'b0;
        take_req   = 1'b0;
        hdr_ld     = 1'b0;
        hdr_sh     = 1'b0;
        hdr_src    = req_q.header;
        wd_sh      = 1'b0;
        do_we      = 1'b0;
        do_nv      = 1'b1;
        oe_we      = 1'b0;
        oe_nv      = 1'b1;
        try_ld     = 1'b0;
        try_dec    = 1'b0;
        fin        = 1'b0;
        fin_rd     = 1'b0;
        fin_status = XS_OK;

        if (phase_q == PH_IDLE) begin
            if (start) begin
                take_req  = 1'b1;
                try_ld    = 1'b1;
                launch    = 1'b1;
                nxt_phase = PH_HDR;
                nxt_left  = LEFT_W'(HDR_W - 1);
                hdr_ld    = 1'b1;
                hdr_src   = req_word[HDR_W-1:0];
                do_we     = 1'b1;
                do_nv     = req_word[0];
                oe_we     = 1'b1;
                oe_nv     = 1'b1;
            end
        end else if (boundary) begin
            if (left_q != '0) begin
                launch   = 1'b1;
                nxt_left = left_q - 1'b1;
                case (phase_q)
                    PH_HDR: begin
                        do_we  = 1'b1;
                        do_nv  = hdr_q[0];
                        hdr_sh = 1'b1;
                    end
                    PH_WR_DATA: begin
                        do_we = 1'b1;
                        do_nv = wd_q[0];
                        wd_sh = 1'b1;
                    end
                    default: ;
                endcase
            end else begin
                case (phase_q)
                    PH_HDR: begin
                        launch    = 1'b1;
                        nxt_phase = PH_ACK;
                        nxt_left  = LEFT_W'(RSP_BITS - 1);
                        oe_we     = 1'b1;
                        oe_nv     = 1'b0;
                    end
                    PH_ACK: begin
                        case (judge_ack(ack_field(ack_sh_q), final_try))
                            VD_PROCEED: begin
                                launch = 1'b1;
                                if (req_q.is_write) begin
                                    nxt_phase = PH_WR_TURN;
                                    nxt_left  = '0;
                                    oe_we     = 1'b1;
                                    oe_nv     = 1'b1;
                                    do_we     = 1'b1;
                                    do_nv     = 1'b0;
                                end else begin
                                    nxt_phase = PH_RD_DATA;
                                    nxt_left  = LEFT_W'(DATA_W - 1);
                                end
                            end
                            VD_RESEND: begin
                                launch    = 1'b1;
                                try_dec   = 1'b1;
                                nxt_phase = PH_HDR;
                                nxt_left  = LEFT_W'(HDR_W - 1);
                                hdr_ld    = 1'b1;
                                hdr_src   = req_q.header;
                                do_we     = 1'b1;
                                do_nv     = req_q.header[0];
                                oe_we     = 1'b1;
                                oe_nv     = 1'b1;
                            end
                            VD_TIMEOUT: begin
                                fin        = 1'b1;
                                fin_status = XS_TIMEOUT;
                            end
                            default: begin
                                fin        = 1'b1;
                                fin_status = XS_FAIL;
                            end
                        endcase
                    end
                    PH_RD_DATA: begin
                        launch    = 1'b1;
                        nxt_phase = PH_RD_PAR;
                        nxt_left  = '0;
                    end
                    PH_RD_PAR: begin
                        launch    = 1'b1;
                        nxt_phase = PH_RD_TURN;
                        nxt_left  = '0;
                    end
                    PH_RD_TURN: begin
                        fin    = 1'b1;
                        fin_rd = 1'b1;
                    end
                    PH_WR_TURN: begin
                        launch    = 1'b1;
                        nxt_phase = PH_WR_DATA;
                        nxt_left  = LEFT_W'(DATA_W - 1);
                        do_we     = 1'b1;
                        do_nv     = wd_q[0];
                        wd_sh     = 1'b1;
                    end
                    PH_WR_DATA: begin
                        launch    = 1'b1;
                        nxt_phase = PH_WR_PAR;
                        nxt_left  = '0;
                        do_we     = 1'b1;
                        do_nv     = req_q.wr_parity;
                    end
                    default: begin
                        fin = 1'b1;
                    end
                endcase
                if (fin) begin
                    nxt_phase = PH_IDLE;
                    nxt_left  = '0;
                    do_we     = 1'b1;
                    do_nv     = 1'b1;
                    oe_we     = 1'b1;
                    oe_nv     = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= PH_IDLE;
            left_q    <= '0;
            req_q     <= '0;
            div_q     <= '0;
            do_q      <= 1'b1;
            oe_q      <= 1'b1;
            done_q    <= 1'b0;
            status_q  <= XS_OK;
            rdat_q    <= '0;
            rpar_q    <= 1'b0;
            par_smp_q <= 1'b0;
            tgt_en_q  <= 1'b0;
        end else begin
            phase_q  <= nxt_phase;
            left_q   <= nxt_left;
            done_q   <= fin;
            tgt_en_q <= 1'b1;
            if (take_req) begin
                req_q <= split_request(req_word, is_write);
                div_q <= half_div;
            end
            if (do_we)
                do_q <= do_nv;
            if (oe_we)
                oe_q <= oe_nv;
            if (fin)
                status_q <= fin_status;
            if (fin_rd) begin
                rdat_q <= rd_sh_q;
                rpar_q <= par_smp_q;
            end
            if (smp && (phase_q == PH_RD_PAR))
                par_smp_q <= line_di;
        end
    end

    assign busy      = (phase_q != PH_IDLE);
    assign done      = done_q;
    assign status    = status_q;
    assign rd_data   = rdat_q;
    assign rd_parity = rpar_q;
    assign line_clk  = link_clk;
    assign line_do   = do_q;
    assign line_oe   = oe_q;
    assign tgt_en    = tgt_en_q;

endmodule

// File: rtl/dbg_wire_master_chk.sv
module dbg_wire_master_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              done,
    input logic [1:0]        status,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_parity,
    input logic              line_clk,
    input logic              line_do,
    input logic              line_oe,
    input logic              tgt_en
);
    assert_idle_lines_R1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (line_clk && line_do && line_oe));

    assert_tgt_en_R1: assert property (@(posedge clk) disable iff (rst)
        !line_clk |-> tgt_en);

    assert_low_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!line_clk && !$past(line_clk)) |-> ($stable(line_do) && $stable(line_oe)));

    assert_fall_only_R3: assert property (@(posedge clk) disable iff (rst)
        ((line_do != $past(line_do)) || (line_oe != $past(line_oe)))
            |-> ((!line_clk && $past(line_clk)) || done));

    assert_release_busy_R4: assert property (@(posedge clk) disable iff (rst)
        !line_oe |-> busy);

    assert_status_code_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> (status != 2'd1));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_rd_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(rd_data) && $stable(rd_parity)));

    assert_status_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(status));
endmodule

bind dbg_wire_master dbg_wire_master_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .done      (done),
    .status    (status),
    .rd_data   (rd_data),
    .rd_parity (rd_parity),
    .line_clk  (line_clk),
    .line_do   (line_do),
    .line_oe   (line_oe),
    .tgt_en    (tgt_en)
);

// File: tb/dbg_wire_master_test.sv
module dbg_wire_master_test;

    localparam int MAXT = 5;

    typedef struct packed {
        logic        wr;
        logic [16:0] req;
        logic [31:0] wd;
        logic [7:0]  div;
        logic [2:0]  ack;
        logic [3:0]  waits;
        logic [31:0] rdat;
        logic        rpar;
        logic [1:0]  est;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 17'h000A5, 32'h0,        8'd0, 3'd1, 4'd0, 32'h12345678, 1'b1, 2'd0},
        '{1'b1, 17'h10081, 32'hDEADBEEF, 8'd1, 3'd1, 4'd2, 32'h0,        1'b0, 2'd0},
        '{1'b0, 17'h000B1, 32'h0,        8'd0, 3'd4, 4'd0, 32'h0,        1'b0, 2'd3},
        '{1'b0, 17'h0008D, 32'h0,        8'd0, 3'd1, 4'd5, 32'h0,        1'b0, 2'd2},
        '{1'b0, 17'h100C3, 32'h0,        8'd2, 3'd1, 4'd4, 32'h80000001, 1'b0, 2'd0},
        '{1'b1, 17'h000A9, 32'h5555AAAA, 8'd0, 3'd7, 4'd1, 32'h0,        1'b0, 2'd3},
        '{1'b1, 17'h00099, 32'h0F0F0F0F, 8'd0, 3'd1, 4'd0, 32'h0,        1'b0, 2'd0},
        '{1'b0, 17'h1FFFF, 32'h0,        8'd0, 3'd1, 4'd0, 32'hFFFFFFFF, 1'b0, 2'd0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        is_write = 1'b0;
    logic [16:0] req_word = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  half_div = '0;
    logic        busy, done, rd_parity, line_clk, line_do, line_oe, tgt_en;
    logic [1:0]  status;
    logic [31:0] rd_data;
    logic        line_di = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    logic tgt_bits [0:255];
    int   tgt_n = 0;
    int   tgt_idx = 0;
    logic cap_bits [0:1023];
    int   cap_n = 0;

    always #5 clk = ~clk;

    dbg_wire_master #(.MAX_TRIES(MAXT)) uut (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .is_write  (is_write),
        .req_word  (req_word),
        .wr_data   (wr_data),
        .half_div  (half_div),
        .busy      (busy),
        .done      (done),
        .status    (status),
        .rd_data   (rd_data),
        .rd_parity (rd_parity),
        .line_clk  (line_clk),
        .line_do   (line_do),
        .line_oe   (line_oe),
        .line_di   (line_di),
        .tgt_en    (tgt_en)
    );

    // Target model: presents the next scripted bit just after each falling
    // clock in which the master has released the line.
    always @(negedge line_clk) begin
        #1;
        if (!line_oe) begin
            line_di = (tgt_idx < tgt_n) ? tgt_bits[tgt_idx] : 1'b0;
            tgt_idx++;
        end
    end

    // Capture every bit the master drives, at the rising clock.
    always @(posedge line_clk) begin
        #1;
        if (line_oe && cap_n < 1024) begin
            cap_bits[cap_n] = line_do;
            cap_n++;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected fewer than 150000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic push_bit(input logic b);
        tgt_bits[tgt_n] = b;
        tgt_n++;
    endtask

    task automatic build_script(input logic [2:0] ack, input int waits, input logic rd,
                                input logic [31:0] rdat, input logic rpar);
        tgt_n   = 0;
        tgt_idx = 0;
        cap_n   = 0;
        for (int a = 0; a < waits && a < MAXT; a++) begin
            push_bit(1'b0); push_bit(1'b0); push_bit(1'b1); push_bit(1'b0);
        end
        if (waits < MAXT) begin
            push_bit(1'b0); push_bit(ack[0]); push_bit(ack[1]); push_bit(ack[2]);
            if (ack == 3'd1 && rd) begin
                for (int i = 0; i < 32; i++) push_bit(rdat[i]);
                push_bit(rpar);
                push_bit(1'b0);
            end
        end
    endtask

    task automatic run_xfer(input logic wr, input logic [16:0] req, input logic [31:0] wd,
                            input logic [7:0] dv);
        @(negedge clk);
        is_write = wr;
        req_word = req;
        wr_data  = wd;
        half_div = dv;
        start    = 1'b1;
        @(negedge clk);
        start    = 1'b0;
    endtask

    task automatic wait_done(output bit seen);
        seen = 1'b0;
        for (int c = 0; c < 20000; c++) begin
            @(negedge clk);
            if (done) begin
                seen = 1'b1;
                break;
            end
        end
    endtask

    task automatic wait_lvl(input logic v);
        for (int c = 0; c < 2000; c++) begin
            if (line_clk === v) break;
            @(negedge clk);
        end
    endtask

    function automatic logic [15:0] cap_hdr(input int base);
        logic [15:0] h;
        for (int i = 0; i < 16; i++) h[i] = cap_bits[base + i];
        return h;
    endfunction

    function automatic logic [31:0] cap_word(input int base);
        logic [31:0] w;
        for (int i = 0; i < 32; i++) w[i] = cap_bits[base + i];
        return w;
    endfunction

    initial begin
        bit          seen;
        logic [31:0] exp_rd;
        logic        exp_par;
        int          attempts;
        int          n_low;
        int          n_high;
        int          n_done;
        string       stag;

        exp_rd  = '0;
        exp_par = 1'b0;

        // Reset state (R1)
        repeat (4) @(negedge clk);
        check("R1 reset lines clk/do/oe/busy/done", {27'd0, line_clk, line_do, line_oe, busy, done}, 32'b11100);
        check("R1 reset status/rd_parity", {29'd0, status, rd_parity}, 32'd0);
        check("R1 reset rd_data", rd_data, 32'd0);
        check("R1 tgt_en low in reset", {31'd0, tgt_en}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 tgt_en high after reset", {31'd0, tgt_en}, 32'd1);

        // Vector table walk
        for (int v = 0; v < NV; v++) begin
            vec_t t;
            t = VECS[v];
            build_script(t.ack, int'(t.waits), !t.wr, t.rdat, t.rpar);
            run_xfer(t.wr, t.req, t.wd, t.div);
            wait_done(seen);
            check("R10 done pulse seen", {31'd0, seen}, 32'd1);
            attempts = (int'(t.waits) >= MAXT) ? MAXT : int'(t.waits) + 1;
            stag = (t.est == 2'd0) ? "R5 status ok" : (t.est == 2'd2) ? "R6 status timeout" : "R7 status fail";
            check(stag, {30'd0, status}, {30'd0, t.est});
            if (!t.wr && t.est == 2'd0) begin
                exp_rd  = t.rdat;
                exp_par = t.rpar;
            end
            check("R8 R10 rd_data", rd_data, exp_rd);
            check("R8 R10 rd_parity", {31'd0, rd_parity}, {31'd0, exp_par});
            check("R2 R9 driven bit count", cap_n,
                  16 * attempts + ((t.wr && t.est == 2'd0) ? 34 : 0));
            check("R4 released clock count", tgt_idx,
                  4 * attempts + ((!t.wr && t.est == 2'd0) ? 34 : 0));
            for (int a = 0; a < attempts; a++) begin
                if (a == 0) check("R2 header bits", {16'd0, cap_hdr(0)}, {16'd0, t.req[15:0]});
                else        check("R6 header resend", {16'd0, cap_hdr(16 * a)}, {16'd0, t.req[15:0]});
            end
            if (t.wr && t.est == 2'd0) begin
                check("R9 write turnaround bit", {31'd0, cap_bits[16 * attempts]}, 32'd0);
                check("R9 write data bits", cap_word(16 * attempts + 1), t.wd);
                check("R9 write parity bit", {31'd0, cap_bits[16 * attempts + 33]}, {31'd0, t.req[16]});
            end
            check("R1 R8 idle lines after end", {27'd0, line_clk, line_do, line_oe, busy}, 32'b1110);
            @(negedge clk);
            check("R10 done single cycle", {31'd0, done}, 32'd0);
        end

        // Half-period and divider capture (R3)
        build_script(3'd1, 0, 1'b1, 32'hA5A5_0F0F, 1'b1);
        run_xfer(1'b0, 17'h000E1, 32'h0, 8'd3);
        half_div = 8'd0;
        wait_lvl(1'b1);
        wait_lvl(1'b0);
        wait_lvl(1'b1);
        wait_lvl(1'b0);
        n_low = 0;
        while (line_clk === 1'b0 && n_low < 100) begin n_low++; @(negedge clk); end
        n_high = 0;
        while (line_clk === 1'b1 && n_high < 100) begin n_high++; @(negedge clk); end
        check("R3 low half length", n_low, 4);
        check("R3 high half length", n_high, 4);
        wait_done(seen);
        check("R3 transfer after divider change", {30'd0, status}, 32'd0);
        check("R3 read data with slow clock", rd_data, 32'hA5A5_0F0F);

        // Start while busy is ignored (R11)
        build_script(3'd1, 0, 1'b0, 32'h0, 1'b0);
        run_xfer(1'b1, 17'h10033, 32'hCAFEF00D, 8'd0);
        repeat (30) @(negedge clk);
        is_write = 1'b0;
        req_word = 17'h000FF;
        half_div = 8'd5;
        start    = 1'b1;
        @(negedge clk);
        start    = 1'b0;
        wait_done(seen);
        check("R11 original write completes", {30'd0, status}, 32'd0);
        check("R11 driven bit count", cap_n, 50);
        check("R11 header unchanged", {16'd0, cap_hdr(0)}, 32'h0033);
        check("R11 write data unchanged", cap_word(17), 32'hCAFEF00D);
        check("R11 rd_data untouched", rd_data, 32'hA5A5_0F0F);
        n_done = 0;
        for (int c = 0; c < 300; c++) begin
            @(negedge clk);
            if (done) n_done++;
        end
        check("R11 no extra transaction", {31'd0, busy}, 32'd0);
        check("R11 no extra done", n_done, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule